// File: doc/BRIEF.md
# Program and Data Memory Access Router

This block sits between a small 8-bit core and its memories. The core has two request ports, each with a 16-bit address. The code-fetch port reads instructions. The data-move port reads and writes data in a separate address space. For every accepted request the router decides where the address lives: on-chip program flash, the 1 kB on-chip data RAM, or the external expanded bus. It then drives the matching on-chip select or the active-low external strobe.

Software sets how much of the program space is on chip. It writes a 3-bit size code and a remap bit into a small configuration register. Code 0 means no on-chip program space. Codes 1 to 7 mean 1 kB, 2 kB, 4 kB, 8 kB, 16 kB, 32 kB and 64 kB, and the result is capped at the flash size of the chosen variant. A parameter picks the variant: 16 kB or 64 kB. When the remap bit is set, the data RAM also appears in code space. It occupies the 1 kB window that starts at the current program limit, at RAM offset (address - limit).

Only one port is served per cycle. When both ports request in the same cycle, the fetch is served and the data port waits. If both ports still request in the following cycle, the data port is served.

Top module: `mem_access_router`

## Requirements
- R1: After reset the size code equals the variant's full flash size (code 5 for the 16 kB variant) and remap is off. A fetch at 0x3FFF selects flash and a fetch at 0x4000 goes external. With no request, the flash select and RAM select are 0, all three external strobes are 1, and both ready outputs are 1.
- R2: For code k in 1..7 the program limit is 1024<<(k-1) bytes, capped at the flash size. A fetch below the limit asserts `flash_cs`. A fetch at or above the limit, outside any remap window, drives `ext_pse_n` low and puts the address on `ext_addr`.
- R3: With code 0, every fetch goes external, including the 128-byte vector area at 0x0000-0x007F.
- R4: A configuration write is used by the fetch in the very next cycle.
- R5: With remap set, a fetch in [limit, limit+1024) asserts `ram_cs`. One cycle later `if_rdata` returns the RAM byte at offset (address - limit).
- R6: A data access below 0x0400 asserts `ram_cs` and leaves all strobes high. At 0x0400 or above, a read drives `ext_rd_n` low and a write drives `ext_wr_n` low. `ext_addr` carries the address, and `ext_wdata` carries the write data.
- R7: The two spaces are separate: the same address reads flash through the fetch port and RAM through the data port.
- R8: On-chip read data appears one cycle after the access. A flash byte is addr[7:0] XOR addr[15:8] XOR 0x5A. A RAM read returns the byte last written there.
- R9: In any cycle at most one of `flash_cs`, `ram_cs`, `ext_pse_n` low, `ext_rd_n` low, `ext_wr_n` low is active.
- R10: When both ports request together, the fetch is served and `dm_ready` is 0. If both still request in the next cycle, the data access is served and `if_ready` is 0.
- R11: A port that does not request causes no select and no strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cfg_we | input | 1 | Write strobe for the configuration register |
| cfg_size_code | input | 3 | Program size code to store |
| cfg_remap | input | 1 | Remap bit to store |
| if_req | input | 1 | Code-fetch request |
| if_addr | input | 16 | Code-fetch address |
| if_ready | output | 1 | Fetch accepted this cycle |
| if_rdata | output | 8 | On-chip fetch data, one cycle after the access |
| dm_req | input | 1 | Data-move request |
| dm_we | input | 1 | Data-move write when 1, read when 0 |
| dm_addr | input | 16 | Data-move address |
| dm_wdata | input | 8 | Data-move write data |
| dm_ready | output | 1 | Data access accepted this cycle |
| dm_rdata | output | 8 | On-chip data read result, one cycle after the access |
| flash_cs | output | 1 | On-chip flash select |
| ram_cs | output | 1 | On-chip RAM select |
| ext_addr | output | 16 | Address of the current external access |
| ext_wdata | output | 8 | Data of the current external write |
| ext_pse_n | output | 1 | External program-store enable, active low |
| ext_rd_n | output | 1 | External read strobe, active low |
| ext_wr_n | output | 1 | External write strobe, active low |

## Verification
The fetch decode is tried with a sweep of size codes. Each fetch is placed exactly at and just below the limit. This separates the correct limit from an off-by-one limit and from an uncapped limit. The same sweep is repeated with remap on, with fetches at both edges of the RAM window and one past it. This separates the window placement from the flash limit. Data accesses on both sides of 0x0400, as reads and as writes, show whether the right strobe fires. Overlapping requests over two cycles show the priority rule and show that a stalled data access is then served.

// File: rtl/mar_pkg.sv
package mar_pkg;
  typedef enum logic [1:0] {
    TGT_EXT   = 2'd0,
    TGT_FLASH = 2'd1,
    TGT_RAM   = 2'd2
  } tgt_e;

  // Size code to byte count: 0 gives none, k gives 1 kB doubled (k-1) times.
  function automatic logic [16:0] code_to_bytes(input logic [2:0] code);
    if (code == 3'd0) return 17'd0;
    return 17'd1024 << (code - 3'd1);
  endfunction

  // Behavioural flash content, computed from the address.
  function automatic logic [7:0] flash_byte(input logic [15:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h5A;
  endfunction
endpackage

// File: rtl/mar_cfg_reg.sv
module mar_cfg_reg #(
  parameter logic [2:0] RESET_CODE = 3'd5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       we,
  input  logic [2:0] code_in,
  input  logic       remap_in,
  output logic [2:0] size_code,
  output logic       remap
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      size_code <= RESET_CODE;
      remap     <= 1'b0;
    end else if (we) begin
      size_code <= code_in;
      remap     <= remap_in;
    end
  end
endmodule

// File: rtl/mar_decode.sv
module mar_decode
  import mar_pkg::*;
#(
  parameter int FLASH_BYTES = 16384,
  parameter int RAM_BYTES   = 1024,
  localparam int RAM_AW     = $clog2(RAM_BYTES)
) (
  input  logic [2:0]        size_code,
  input  logic              remap,
  input  logic [15:0]       if_addr,
  input  logic [15:0]       dm_addr,
  output tgt_e              if_tgt,
  output tgt_e              dm_tgt,
  output logic [RAM_AW-1:0] if_ram_off
);
  localparam logic [16:0] FL_LIM  = 17'(FLASH_BYTES);
  localparam logic [16:0] RAM_LIM = 17'(RAM_BYTES);

  logic [16:0] code_lim, eff_lim, addr17, delta;

  always_comb begin
    code_lim   = code_to_bytes(size_code);
    eff_lim    = (code_lim > FL_LIM) ? FL_LIM : code_lim;
    addr17     = {1'b0, if_addr};
    delta      = addr17 - eff_lim;
    if_ram_off = delta[RAM_AW-1:0];
    if (addr17 < eff_lim)
      if_tgt = TGT_FLASH;
    else if (remap && (delta < RAM_LIM))
      if_tgt = TGT_RAM;
    else
      if_tgt = TGT_EXT;
    dm_tgt = ({1'b0, dm_addr} < RAM_LIM) ? TGT_RAM : TGT_EXT;
  end
endmodule

// File: rtl/mar_arbiter.sv
module mar_arbiter (
  input  logic clk,
  input  logic rst_n,
  input  logic if_req,
  input  logic dm_req,
  output logic if_go,
  output logic dm_go,
  output logic if_ready,
  output logic dm_ready
);
  logic both, stalled_q;

  assign both     = if_req & dm_req;
  assign if_ready = ~(both & stalled_q);
  assign dm_ready = ~(both & ~stalled_q);
  assign if_go    = if_req & if_ready;
  assign dm_go    = dm_req & dm_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stalled_q <= 1'b0;
    else        stalled_q <= dm_req & ~dm_go;
  end

  // A data request held off once is served next time both collide.
  assert_stall_one_cycle_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (if_req && dm_req && !dm_ready) |=> (!(if_req && dm_req) || (dm_ready && !if_ready)));
  // The data port is only held off by a fetch.
  assert_stall_needs_fetch_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (dm_req && !dm_ready) |-> (if_req && if_go));
endmodule

// File: rtl/mar_mem.sv
module mar_mem
  import mar_pkg::*;
#(
  parameter int RAM_BYTES = 1024,
  localparam int RAM_AW   = $clog2(RAM_BYTES)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              if_go,
  input  tgt_e              if_tgt,
  input  logic [15:0]       if_addr,
  input  logic [RAM_AW-1:0] if_ram_off,
  input  logic              dm_go,
  input  tgt_e              dm_tgt,
  input  logic              dm_we,
  input  logic [15:0]       dm_addr,
  input  logic [7:0]        dm_wdata,
  output logic [7:0]        if_rdata,
  output logic [7:0]        dm_rdata
);
  logic [7:0] ram [RAM_BYTES];
  logic       ram_wr;

  assign ram_wr = dm_go & dm_we & (dm_tgt == TGT_RAM);

  always_ff @(posedge clk) begin
    if (ram_wr) ram[dm_addr[RAM_AW-1:0]] <= dm_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      if_rdata <= 8'd0;
      dm_rdata <= 8'd0;
    end else begin
      if (if_go) begin
        unique case (if_tgt)
          TGT_FLASH: if_rdata <= flash_byte(if_addr);
          TGT_RAM:   if_rdata <= ram[if_ram_off];
          default:   if_rdata <= 8'd0;
        endcase
      end
      if (dm_go && !dm_we)
        dm_rdata <= (dm_tgt == TGT_RAM) ? ram[dm_addr[RAM_AW-1:0]] : 8'd0;
    end
  end
endmodule

// File: rtl/mem_access_router.sv
module mem_access_router
  import mar_pkg::*;
#(
  parameter bit LARGE_VARIANT = 1'b0,
  parameter int RAM_BYTES     = 1024,
  localparam int FLASH_BYTES  = LARGE_VARIANT ? 65536 : 16384,
  localparam logic [2:0] RESET_CODE = LARGE_VARIANT ? 3'd7 : 3'd5,
  localparam int RAM_AW       = $clog2(RAM_BYTES)
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_we,
  input  logic [2:0]  cfg_size_code,
  input  logic        cfg_remap,
  input  logic        if_req,
  input  logic [15:0] if_addr,
  output logic        if_ready,
  output logic [7:0]  if_rdata,
  input  logic        dm_req,
  input  logic        dm_we,
  input  logic [15:0] dm_addr,
  input  logic [7:0]  dm_wdata,
  output logic        dm_ready,
  output logic [7:0]  dm_rdata,
  output logic        flash_cs,
  output logic        ram_cs,
  output logic [15:0] ext_addr,
  output logic [7:0]  ext_wdata,
  output logic        ext_pse_n,
  output logic        ext_rd_n,
  output logic        ext_wr_n
);
  logic [2:0]        size_code;
  logic              remap;
  tgt_e              if_tgt, dm_tgt;
  logic [RAM_AW-1:0] if_ram_off;
  logic              if_go, dm_go;
  // Named internal events, brought out for the assertions.
  logic              fetch_ext, data_rd_ext, data_wr_ext;

  mar_cfg_reg #(.RESET_CODE(RESET_CODE)) u_cfg (
    .clk(clk), .rst_n(rst_n), .we(cfg_we), .code_in(cfg_size_code),
    .remap_in(cfg_remap), .size_code(size_code), .remap(remap)
  );

  mar_decode #(.FLASH_BYTES(FLASH_BYTES), .RAM_BYTES(RAM_BYTES)) u_dec (
    .size_code(size_code), .remap(remap), .if_addr(if_addr), .dm_addr(dm_addr),
    .if_tgt(if_tgt), .dm_tgt(dm_tgt), .if_ram_off(if_ram_off)
  );

  mar_arbiter u_arb (
    .clk(clk), .rst_n(rst_n), .if_req(if_req), .dm_req(dm_req),
    .if_go(if_go), .dm_go(dm_go), .if_ready(if_ready), .dm_ready(dm_ready)
  );

  mar_mem #(.RAM_BYTES(RAM_BYTES)) u_mem (
    .clk(clk), .rst_n(rst_n), .if_go(if_go), .if_tgt(if_tgt), .if_addr(if_addr),
    .if_ram_off(if_ram_off), .dm_go(dm_go), .dm_tgt(dm_tgt), .dm_we(dm_we),
    .dm_addr(dm_addr), .dm_wdata(dm_wdata), .if_rdata(if_rdata), .dm_rdata(dm_rdata)
  );

  assign fetch_ext   = if_go & (if_tgt == TGT_EXT);
  assign data_rd_ext = dm_go & ~dm_we & (dm_tgt == TGT_EXT);
  assign data_wr_ext = dm_go &  dm_we & (dm_tgt == TGT_EXT);

  assign flash_cs  = if_go & (if_tgt == TGT_FLASH);
  assign ram_cs    = (if_go & (if_tgt == TGT_RAM)) | (dm_go & (dm_tgt == TGT_RAM));
  assign ext_pse_n = ~fetch_ext;
  assign ext_rd_n  = ~data_rd_ext;
  assign ext_wr_n  = ~data_wr_ext;
  assign ext_addr  = fetch_ext ? if_addr : ((data_rd_ext | data_wr_ext) ? dm_addr : 16'd0);
  assign ext_wdata = data_wr_ext ? dm_wdata : 8'd0;

  assert_one_strobe_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({flash_cs, ram_cs, ~ext_pse_n, ~ext_rd_n, ~ext_wr_n}));
  assert_idle_quiet_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (!if_req && !dm_req) |-> (!flash_cs && !ram_cs && ext_pse_n && ext_rd_n && ext_wr_n));
  assert_code0_no_flash_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (size_code == 3'd0) |-> !flash_cs);
  assert_pse_is_fetch_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !ext_pse_n |-> (if_req && if_ready && ext_addr == if_addr));
  assert_rd_outside_ram_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!ext_rd_n || !ext_wr_n) |-> ({1'b0, dm_addr} >= 17'(RAM_BYTES)));
endmodule

// File: tb/sim_mem_access_router.sv
`timescale 1ns/1ps
module sim_mem_access_router;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0, cfg_remap = 0;
  logic [2:0] cfg_size_code = 0;
  logic if_req = 0, dm_req = 0, dm_we = 0;
  logic [15:0] if_addr = 0, dm_addr = 0;
  logic [7:0] dm_wdata = 0;
  logic if_ready, dm_ready, flash_cs, ram_cs, ext_pse_n, ext_rd_n, ext_wr_n;
  logic [7:0] if_rdata, dm_rdata, ext_wdata;
  logic [15:0] ext_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  mem_access_router u0 (.*);

  // {size code, remap, fetch address, expected target: 0 ext, 1 flash, 2 ram}
  localparam logic [21:0] VEC [16] = '{
    {3'd5, 1'b0, 16'h3FFF, 2'd1}, {3'd5, 1'b0, 16'h4000, 2'd0},
    {3'd1, 1'b0, 16'h03FF, 2'd1}, {3'd1, 1'b0, 16'h0400, 2'd0},
    {3'd3, 1'b0, 16'h0FFF, 2'd1}, {3'd4, 1'b0, 16'h2000, 2'd0},
    {3'd7, 1'b0, 16'h4000, 2'd0}, {3'd6, 1'b0, 16'h3FFF, 2'd1},
    {3'd0, 1'b0, 16'h0000, 2'd0}, {3'd0, 1'b0, 16'h007F, 2'd0},
    {3'd2, 1'b1, 16'h0800, 2'd2}, {3'd2, 1'b1, 16'h0BFF, 2'd2},
    {3'd2, 1'b1, 16'h0C00, 2'd0}, {3'd0, 1'b1, 16'h0000, 2'd2},
    {3'd7, 1'b1, 16'h4000, 2'd2}, {3'd5, 1'b0, 16'h0000, 2'd1}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_flash(input logic [15:0] a);
    logic [7:0] v = 8'h5A;
    v = v ^ a[15:8];
    return v ^ a[7:0];
  endfunction

  task automatic set_cfg(input logic [2:0] code, input logic rm);
    @(negedge clk);
    cfg_we = 1; cfg_size_code = code; cfg_remap = rm;
    @(posedge clk); #1;
    cfg_we = 0;
  endtask

  // Drive both ports at the falling edge, then let combinational outputs settle.
  task automatic drive(input logic fr, input logic [15:0] fa, input logic dr,
                       input logic dw, input logic [15:0] da, input logic [7:0] dd);
    @(negedge clk);
    if_req = fr; if_addr = fa; dm_req = dr; dm_we = dw; dm_addr = da; dm_wdata = dd;
    #2;
  endtask

  task automatic tick_idle();
    @(posedge clk); #1;
    if_req = 0; dm_req = 0;
  endtask

  function automatic int strobes();
    return int'(flash_cs) + int'(ram_cs) + int'(!ext_pse_n) + int'(!ext_rd_n) + int'(!ext_wr_n);
  endfunction

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R1 / R11: idle after reset
    drive(0, 0, 0, 0, 0, 0);
    chk("R1 idle strobes", {flash_cs, ram_cs, ext_pse_n, ext_rd_n, ext_wr_n}, 5'b00111);
    chk("R11 readies", {if_ready, dm_ready}, 2'b11);
    // R1: reset limit is 16 kB
    drive(1, 16'h3FFF, 0, 0, 0, 0);
    chk("R1 fetch 3FFF flash", flash_cs, 1);
    drive(1, 16'h4000, 0, 0, 0, 0);
    chk("R1 fetch 4000 ext", {flash_cs, ext_pse_n}, 2'b00);
    tick_idle();

    // Vector walk: R2, R3, R4, R5 targets, R8 flash data, R9 exclusivity
    foreach (VEC[i]) begin
      logic [2:0] code = VEC[i][21:19];
      logic rm = VEC[i][18];
      logic [15:0] a = VEC[i][17:2];
      logic [1:0] t = VEC[i][1:0];
      set_cfg(code, rm);
      drive(1, a, 0, 0, 0, 0);   // R4: fetch in the cycle after the write
      chk("R2/R3/R4 flash_cs", flash_cs, t == 2'd1);
      chk("R5 ram_cs", ram_cs, t == 2'd2);
      chk("R2 ext_pse_n", ext_pse_n, t != 2'd0);
      if (t == 2'd0) chk("R2 ext_addr", ext_addr, a);
      chk("R9 one strobe", strobes(), 1);
      @(posedge clk); #1;
      if (t == 2'd1) chk("R8 flash data", if_rdata, exp_flash(a));
      if_req = 0;
    end

    // R6 / R8: data port
    set_cfg(3'd5, 1'b0);
    drive(0, 0, 1, 1, 16'h0010, 8'hA5);
    chk("R6 ram write", {ram_cs, ext_wr_n, ext_rd_n}, 3'b111);
    tick_idle();
    drive(0, 0, 1, 1, 16'h0400, 8'hC3);
    chk("R6 ext write", {ram_cs, ext_wr_n, ext_rd_n}, 3'b001);
    chk("R6 ext write addr/data", {ext_addr, ext_wdata}, {16'h0400, 8'hC3});
    tick_idle();
    drive(0, 0, 1, 0, 16'hFFFF, 0);
    chk("R6 ext read", {ram_cs, ext_rd_n, ext_wr_n}, 3'b001);
    tick_idle();
    drive(0, 0, 1, 0, 16'h0010, 0);
    chk("R6 ram read select", {ram_cs, ext_rd_n}, 2'b11);
    @(posedge clk); #1;
    chk("R8 ram read data", dm_rdata, 8'hA5);
    dm_req = 0;

    // R7: same address, two spaces
    drive(1, 16'h0010, 0, 0, 0, 0);
    @(posedge clk); #1;
    chk("R7 fetch 0010 sees flash", if_rdata, exp_flash(16'h0010));
    if_req = 0;

    // R5: remapped fetch returns RAM data at offset addr - limit
    drive(0, 0, 1, 1, 16'h0005, 8'h3C);
    tick_idle();
    set_cfg(3'd2, 1'b1);
    drive(1, 16'h0805, 0, 0, 0, 0);
    chk("R5 remap select", ram_cs, 1);
    @(posedge clk); #1;
    chk("R5 remap data", if_rdata, 8'h3C);
    if_req = 0;

    // R10: collision, fetch first then data
    set_cfg(3'd5, 1'b0);
    drive(1, 16'h8000, 1, 0, 16'h0800, 0);
    chk("R10 fetch wins", {if_ready, dm_ready, ext_pse_n, ext_rd_n}, 4'b1001);
    @(posedge clk);
    #3;
    chk("R10 data next", {if_ready, dm_ready, ext_pse_n, ext_rd_n}, 4'b0110);
    tick_idle();
    drive(0, 0, 0, 0, 0, 0);
    chk("R11 quiet after", strobes(), 0);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: actual running expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule